// File: doc/BRIEF.md
# Key-Protected DRAM Controller Register File

This block holds the 32-bit configuration space of a DRAM controller behind a word-addressed read/write port with byte offsets. Most registers are guarded by a lock. The lock opens only when an exact unlock key is written to the protection word at offset 0x00. A second key freezes the guarded registers until the next reset. A short allow-list of status and test registers ignores the lock altogether.

A few registers clean up the data written to them. The configuration word keeps its read-only fields and has its version, aperture and RAM-size fields forced. The PHY status word can never read busy and always reads PLL-locked. The ECC test control word always reports finished and never reports fail.

Two straps set the power-up state: a 2-bit RAM-size code and a reset-unlocked strap. A write dropped by the lock pulses an error output for one cycle, so that a checker can see the lock being enforced. Reads return data one cycle after the request.

Top module: `sdmc_cfg_regs`

## Requirements
- R1: After reset, the protection word reads 0x00, or 0x01 when `boot_unlocked` is high. The configuration word (offset 0x04) reads 0x3000000C OR the size code. The word at 0x400 reads 0x2, 0x450 reads 0x0FFFFFFF, and 0x468 and 0x47C read 0xFF. Every other word reads 0.
- R2: Writing exactly 0xFC600309 to offset 0x00 makes it read 0x01 (unlocked), unless hard-locked. While unlocked, every in-range write is stored.
- R3: Writing exactly 0xDEADDEAD to offset 0x00 makes it read 0x10 (hard-locked). After that, guarded writes are dropped until reset, including writes to offset 0x00.
- R4: Writing any other value to offset 0x00, when not hard-locked, makes it read 0x00 (soft-locked). While soft-locked, guarded writes other than offset 0x00 are dropped and stored words keep their values.
- R5: The words at offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C and 0xB4 accept every write in every lock state and never raise `wr_drop`.
- R6: A write to offset 0x04 stores the written value with bits 31:28, 19:14, 6, 3:2 and 1:0 replaced. Bits 31:28 become 3, bits 3:2 become 3, bits 1:0 take the size code, and bits 19:14 and 6 become 0. The size code is 0 for 256 MiB, 1 for 512 MiB, 2 for 1 GiB and 3 for 2 GiB.
- R7: A write to offset 0x60 stores the value with bit 0 cleared and bit 4 set.
- R8: A write to offset 0x70 stores the value with bit 12 set and bit 13 cleared.
- R9: A word index at or above `NUM_WORDS` (default 320 words, in a 4 KiB window) reads 0. A write there changes nothing and raises no `wr_drop`.
- R10: `rd_valid` is high in exactly the cycle after a cycle with `rd_en`, and `rdata` carries the addressed word in that cycle.
- R11: `wr_drop` is high for one cycle after each write that the lock drops, and is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_unlocked | input | 1 | Strap: protection resets to unlocked |
| mem_size_code | input | 2 | Strap: RAM-size code, 0..3 = 256 MiB..2 GiB |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W (12) | Byte offset; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| wr_drop | output | 1 | One-cycle pulse for a write dropped by the lock |

## Verification
Each of the four size codes is applied through reset, and the whole reset image is read back. This separates the strap-derived configuration field from the fixed reset words. The full word range is then swept with an address-dependent pattern in the soft, unlocked and hard states. In the soft and hard states, `wr_drop` and the read-back must split the allow-list from the guarded words. In the unlocked sweep the stored values must show the per-register clean-up on exactly three words. Near-miss keys, attempts to relock from hard-lock, and offsets past the array separate the exact-key compare and the sticky state from ordinary writes.

// File: rtl/sdmc_cfg_pkg.sv
package sdmc_cfg_pkg;

    typedef enum logic [1:0] {
        LK_SOFT = 2'd0,
        LK_OPEN = 2'd1,
        LK_HARD = 2'd2
    } lock_e;

    localparam logic [31:0] KEY_UNLOCK   = 32'hFC60_0309;
    localparam logic [31:0] KEY_HARDLOCK = 32'hDEAD_DEAD;

    // word indices (byte offset / 4)
    localparam int W_PROT    = 0;
    localparam int W_CONF    = 1;
    localparam int W_PHYSTAT = 24;   // 0x60
    localparam int W_ECCTEST = 28;   // 0x70
    localparam int W_PHYOK   = 256;  // 0x400
    localparam int W_EYE_A   = 276;  // 0x450
    localparam int W_EYE_B   = 282;  // 0x468
    localparam int W_EYE_C   = 287;  // 0x47C

    localparam logic [31:0] CONF_KEEP_MASK = 32'hF00F_C04F;

    function automatic logic [31:0] lock_code(lock_e st);
        case (st)
            LK_OPEN: return 32'h0000_0001;
            LK_HARD: return 32'h0000_0010;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic lock_e key_decode(logic [31:0] d);
        if (d == KEY_UNLOCK)   return LK_OPEN;
        if (d == KEY_HARDLOCK) return LK_HARD;
        return LK_SOFT;
    endfunction

    function automatic logic word_is_open(int idx);
        case (idx)
            20, 27, 29, 30, 31, 34, 35, 45: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] conf_fixed(logic [1:0] sz);
        return 32'h3000_000C | {30'd0, sz};
    endfunction

    function automatic logic [31:0] shape_word(int idx, logic [31:0] d, logic [1:0] sz);
        case (idx)
            W_CONF:    return (d & ~CONF_KEEP_MASK) | conf_fixed(sz);
            W_PHYSTAT: return (d & ~32'h1) | 32'h10;
            W_ECCTEST: return (d | 32'h1000) & ~32'h2000;
            default:   return d;
        endcase
    endfunction

    function automatic logic [31:0] reset_word(int idx, logic [1:0] sz);
        case (idx)
            W_CONF:           return conf_fixed(sz);
            W_PHYOK:          return 32'h0000_0002;
            W_EYE_A:          return 32'h0FFF_FFFF;
            W_EYE_B, W_EYE_C: return 32'h0000_00FF;
            default:          return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sdmc_key_lock.sv
module sdmc_key_lock
    import sdmc_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        boot_unlocked,
    input  logic        req_valid,
    input  logic        req_prot,
    input  logic        req_open,
    input  logic [31:0] req_data,
    output logic        accept,
    output logic        drop_q,
    output lock_e       lock_q
);

    always_comb begin
        accept = 1'b0;
        if (req_valid) begin
            if (req_open)
                accept = 1'b1;
            else if (lock_q != LK_HARD)
                accept = req_prot || (lock_q == LK_OPEN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= boot_unlocked ? LK_OPEN : LK_SOFT;
            drop_q <= 1'b0;
        end else begin
            drop_q <= req_valid && !accept;
            if (accept && req_prot)
                lock_q <= key_decode(req_data);
        end
    end

endmodule

// File: rtl/sdmc_wr_shaper.sv
module sdmc_wr_shaper
    import sdmc_cfg_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      din,
    input  logic [1:0]       size_code,
    output logic [31:0]      dout
);

    always_comb dout = shape_word(int'(idx), din, size_code);

endmodule

// File: rtl/sdmc_word_store.sv
module sdmc_word_store
    import sdmc_cfg_pkg::*;
#(
    parameter int NUM_WORDS = 320,
    parameter int IDX_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       size_code,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [31:0]      w_data,
    input  logic [IDX_W-1:0] r_idx,
    output logic [31:0]      r_data
);

    localparam logic [IDX_W:0] NUM_W = NUM_WORDS[IDX_W:0];

    logic [31:0] mem [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++)
                mem[i] <= reset_word(i, size_code);
        end else if (we && ({1'b0, w_idx} < NUM_W)) begin
            mem[w_idx] <= w_data;
        end
    end

    always_comb r_data = ({1'b0, r_idx} < NUM_W) ? mem[r_idx] : 32'h0;

endmodule

// File: rtl/sdmc_cfg_regs.sv
module sdmc_cfg_regs
    import sdmc_cfg_pkg::*;
#(
    parameter int NUM_WORDS = 320,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_unlocked,
    input  logic [1:0]        mem_size_code,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rd_valid,
    output logic              wr_drop
);

    localparam int             IDX_W = ADDR_W - 2;
    localparam logic [IDX_W:0] NUM_W = NUM_WORDS[IDX_W:0];

    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             is_prot;
    logic             is_open;
    logic             accept;
    lock_e            lock_q;
    logic [31:0]      shaped;
    logic [31:0]      store_rd;

    assign idx      = addr[ADDR_W-1:2];
    assign in_range = {1'b0, idx} < NUM_W;
    assign is_prot  = (idx == '0);
    assign is_open  = word_is_open(int'(idx));

    sdmc_key_lock lock_i (
        .clk          (clk),
        .rst          (rst),
        .boot_unlocked(boot_unlocked),
        .req_valid    (wr_en && in_range),
        .req_prot     (is_prot),
        .req_open     (is_open),
        .req_data     (wdata),
        .accept       (accept),
        .drop_q       (wr_drop),
        .lock_q       (lock_q)
    );

    sdmc_wr_shaper #(.IDX_W(IDX_W)) shaper_i (
        .idx      (idx),
        .din      (wdata),
        .size_code(mem_size_code),
        .dout     (shaped)
    );

    sdmc_word_store #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) store_i (
        .clk      (clk),
        .rst      (rst),
        .size_code(mem_size_code),
        .we       (accept && !is_prot),
        .w_idx    (idx),
        .w_data   (shaped),
        .r_idx    (idx),
        .r_data   (store_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= 32'h0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rdata <= is_prot ? lock_code(lock_q) : store_rd;
        end
    end

endmodule

// File: rtl/sdmc_cfg_regs_chk.sv
module sdmc_cfg_regs_chk
    import sdmc_cfg_pkg::*;
#(
    parameter int NUM_WORDS = 320,
    parameter int ADDR_W    = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              rd_valid,
    input logic              wr_drop,
    input lock_e             lock_q
);

    localparam int             IDX_W = ADDR_W - 2;
    localparam logic [IDX_W:0] NUM_W = NUM_WORDS[IDX_W:0];

    logic [IDX_W-1:0] c_idx;
    logic             c_in;
    logic             c_open;
    assign c_idx  = addr[ADDR_W-1:2];
    assign c_in   = {1'b0, c_idx} < NUM_W;
    assign c_open = word_is_open(int'(c_idx));

    a_r10_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    a_r10_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    a_r3_hard_sticky: assert property (@(posedge clk) disable iff (rst)
        lock_q == LK_HARD |=> lock_q == LK_HARD);
    a_r2_unlock_key: assert property (@(posedge clk) disable iff (rst)
        (wr_en && c_idx == '0 && wdata == KEY_UNLOCK && lock_q != LK_HARD) |=> lock_q == LK_OPEN);
    a_r4_soft_drops: assert property (@(posedge clk) disable iff (rst)
        (wr_en && c_in && c_idx != '0 && !c_open && lock_q == LK_SOFT) |=> wr_drop);
    a_r5_open_never_drops: assert property (@(posedge clk) disable iff (rst)
        (wr_en && c_open) |=> !wr_drop);
    a_r9_oob_no_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !c_in) |=> !wr_drop);
    a_r11_drop_needs_write: assert property (@(posedge clk) disable iff (rst)
        wr_drop |-> $past(wr_en));

endmodule

bind sdmc_cfg_regs sdmc_cfg_regs_chk #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rd_valid(rd_valid),
    .wr_drop (wr_drop),
    .lock_q  (lock_q)
);

// File: tb/sdmc_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module sdmc_cfg_regs_tb_top;

    localparam int NW = 320;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_unlocked = 1'b0;
    logic [1:0]  mem_size_code = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid;
    logic        wr_drop;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdmc_cfg_regs dut_i (
        .clk(clk), .rst(rst), .boot_unlocked(boot_unlocked),
        .mem_size_code(mem_size_code), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .wr_drop(wr_drop)
    );

    function automatic bit open_w(int w);
        return (w == 20) || (w == 27) || (w == 29) || (w == 30) ||
               (w == 31) || (w == 34) || (w == 35) || (w == 45);
    endfunction

    function automatic logic [31:0] exp_reset(int w, logic [1:0] sz);
        if (w == 1)   return 32'h3000_000C + 32'(sz);
        if (w == 256) return 32'h2;
        if (w == 276) return 32'h0FFF_FFFF;
        if (w == 282 || w == 287) return 32'hFF;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_shape(int w, logic [31:0] d, logic [1:0] sz);
        if (w == 1)  return (d & 32'h0FF0_3FB0) | 32'h3000_000C | 32'(sz);
        if (w == 24) return (d & 32'hFFFF_FFFE) | 32'h10;
        if (w == 28) return (d & 32'hFFFF_DFFF) | 32'h1000;
        return d;
    endfunction

    function automatic logic [31:0] pat(int w, logic [15:0] seed);
        return {16'(w) ^ seed, ~(16'(w) + seed)};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [1:0] sz, logic strap);
        @(negedge clk);
        mem_size_code = sz;
        boot_unlocked = strap;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, output logic drop);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        drop = wr_drop;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1, "R10 rd_valid", 32'(rd_valid), 32'h1);
        d = rdata;
    endtask

    initial begin
        logic        dr;
        logic [31:0] v;

        // R1 / R6: reset image for every size code
        for (int sz = 0; sz < 4; sz++) begin
            do_reset(2'(sz), 1'b0);
            @(negedge clk);
            check(rd_valid === 1'b0, "R10 idle", 32'(rd_valid), 32'h0);
            rd(12'h000, v); check(v == 32'h0, "R1 prot reset", v, 32'h0);
            for (int w = 1; w < NW; w++) begin
                rd(12'(w * 4), v);
                check(v == exp_reset(w, 2'(sz)), "R1 reset word", v, exp_reset(w, 2'(sz)));
            end
        end

        // R1: reset-unlocked strap
        do_reset(2'd2, 1'b1);
        rd(12'h000, v); check(v == 32'h1, "R1 strap unlocked", v, 32'h1);
        wr(12'h008, 32'h1234_5678, dr); check(dr == 1'b0, "R11 no drop", 32'(dr), 32'h0);
        rd(12'h008, v); check(v == 32'h1234_5678, "R2 strap write lands", v, 32'h1234_5678);

        // R4 / R5 / R11: soft-locked sweep
        do_reset(2'd1, 1'b0);
        for (int w = 1; w < NW; w++) begin
            wr(12'(w * 4), pat(w, 16'hA55A), dr);
            check(dr == !open_w(w), "R11 soft drop pulse", 32'(dr), 32'(!open_w(w)));
        end
        for (int w = 1; w < NW; w++) begin
            logic [31:0] e;
            e = open_w(w) ? pat(w, 16'hA55A) : exp_reset(w, 2'd1);
            rd(12'(w * 4), v);
            check(v == e, "R4 R5 soft readback", v, e);
        end

        // R4: near-miss key stays soft
        wr(12'h000, 32'hFC60_0308, dr);
        rd(12'h000, v); check(v == 32'h0, "R4 near key", v, 32'h0);

        // R2 / R6 / R7 / R8: unlocked sweep
        wr(12'h000, 32'hFC60_0309, dr); check(dr == 1'b0, "R11 key no drop", 32'(dr), 32'h0);
        rd(12'h000, v); check(v == 32'h1, "R2 unlocked code", v, 32'h1);
        for (int w = 1; w < NW; w++) begin
            wr(12'(w * 4), pat(w, 16'h3CC3), dr);
            check(dr == 1'b0, "R2 unlocked no drop", 32'(dr), 32'h0);
        end
        for (int w = 1; w < NW; w++) begin
            logic [31:0] e;
            e = exp_shape(w, pat(w, 16'h3CC3), 2'd1);
            rd(12'(w * 4), v);
            check(v == e, "R2 R6 R7 R8 stored", v, e);
        end
        wr(12'h004, 32'hFFFF_FFFF, dr);
        rd(12'h004, v); check(v == 32'h3FF0_3FBD, "R6 conf all ones", v, 32'h3FF0_3FBD);
        wr(12'h060, 32'h0000_0001, dr);
        rd(12'h060, v); check(v == 32'h10, "R7 status", v, 32'h10);
        wr(12'h070, 32'h0000_2000, dr);
        rd(12'h070, v); check(v == 32'h1000, "R8 ecc test", v, 32'h1000);

        // R4: any other value relocks softly
        wr(12'h000, 32'h0, dr);
        rd(12'h000, v); check(v == 32'h0, "R4 relock", v, 32'h0);
        wr(12'h008, 32'hDEAD_0000, dr); check(dr == 1'b1, "R4 drop", 32'(dr), 32'h1);
        rd(12'h008, v); check(v == pat(2, 16'h3CC3), "R4 kept", v, pat(2, 16'h3CC3));

        // R3: hard lock from soft
        wr(12'h000, 32'hDEAD_DEAD, dr);
        rd(12'h000, v); check(v == 32'h10, "R3 hard code", v, 32'h10);
        wr(12'h000, 32'hFC60_0309, dr); check(dr == 1'b1, "R3 key dropped", 32'(dr), 32'h1);
        rd(12'h000, v); check(v == 32'h10, "R3 still hard", v, 32'h10);
        wr(12'h004, 32'h0, dr); check(dr == 1'b1, "R3 conf dropped", 32'(dr), 32'h1);
        rd(12'h004, v); check(v == 32'h3FF0_3FBD, "R3 conf kept", v, 32'h3FF0_3FBD);
        for (int w = 1; w < 64; w++) begin
            wr(12'(w * 4), 32'h0BAD_F00D, dr);
            check(dr == !open_w(w), "R5 hard drop pulse", 32'(dr), 32'(!open_w(w)));
        end
        rd(12'h050, v); check(v == 32'h0BAD_F00D, "R5 open while hard", v, 32'h0BAD_F00D);
        rd(12'h0B4, v); check(v == 32'h0BAD_F00D, "R5 open 0xB4", v, 32'h0BAD_F00D);

        // R9: beyond the array
        wr(12'h800, 32'hFFFF_FFFF, dr); check(dr == 1'b0, "R9 oob no drop", 32'(dr), 32'h0);
        rd(12'h800, v); check(v == 32'h0, "R9 oob read", v, 32'h0);
        rd(12'hFFC, v); check(v == 32'h0, "R9 top read", v, 32'h0);

        // R3: reset releases hard lock
        do_reset(2'd3, 1'b0);
        rd(12'h000, v); check(v == 32'h0, "R3 reset clears", v, 32'h0);
        rd(12'h004, v); check(v == 32'h3000_000F, "R1 conf size3", v, 32'h3000_000F);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule